// File: doc/BRIEF.md
# Per-Channel Gamma Lookup Stage

This block sits in a streaming display pixel path and applies gamma correction to each colour component on its own. Red, green and blue each have a private table of 256 eight-bit entries, indexed by the incoming 8-bit component. A table-enable input picks between the looked-up value and an exact copy of the input, so that turning gamma off costs nothing and behaves like a linear table.

Software fills the tables through a two-register write port. An address register sets the starting write index and arms the table memory for writes. A data register then stores one entry per write and steps the index forward, walking through the red table, then green, then blue. Each data write carries a 16-bit colour value, of which only the upper eight bits are kept. Table writes run alongside the pixel stream without stalling it.

Top module: `gamma_lut_stage`

## Requirements
- R1: With `gammaEn` high, a pixel accepted with `pixValid` leaves with `outR`, `outG` and `outB` equal to the red, green and blue table entries addressed by `pixR`, `pixG` and `pixB`. Each table holds 256 entries of 8 bits.
- R2: With `gammaEn` low, an accepted pixel leaves with each output component equal to its input component, bit for bit.
- R3: A data write (`cfgWrEn` high, `cfgSel` = 1) stores `cfgWData[15:8]` into the entry at the current write index and then advances the index by one. Bits [7:0] and [31:16] of the word are not stored.
- R4: The write index is 10 bits wide. Bits [7:0] select the entry, and bits [9:8] select the colour: 0 red, 1 green, 2 blue. After blue entry 255, the index moves to red entry 0. In colour 3, data writes store nothing but still advance the index, and 3/255 wraps to red entry 0.
- R5: While the arm bit is clear, data writes neither store anything nor move the index. The arm bit is clear after reset.
- R6: An address write (`cfgWrEn` high, `cfgSel` = 0) loads the write index from `cfgWData[9:0]` and loads the arm bit from `cfgWData[30]`.
- R7: Outputs appear one clock after a pixel is accepted. `outValid` is `pixValid` delayed by one cycle. The pixel outputs hold their value in any cycle that follows a cycle without `pixValid`.
- R8: Table writes never stall the pixel path. A pixel that reads an entry in the same cycle that entry is written gets the old value. A pixel in the following cycle gets the new value.
- R9: While reset is asserted, and after it until the first pixel, `outValid` is 0 and all pixel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 1 | Register select: 0 address, 1 data |
| cfgWData | input | 32 | Register write data |
| gammaEn | input | 1 | 1 applies the tables, 0 passes pixels through |
| pixValid | input | 1 | Input pixel valid |
| pixR | input | 8 | Input red component |
| pixG | input | 8 | Input green component |
| pixB | input | 8 | Input blue component |
| outValid | output | 1 | Output pixel valid |
| outR | output | 8 | Output red component |
| outG | output | 8 | Output green component |
| outB | output | 8 | Output blue component |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid delay and that outputs hold between valid pixels;
- exact pass-through when the enable is low;
- that at most one table is written per cycle;
- that table writes come only from data-register writes.

Some behaviours only the bench scenarios can show, because they depend on table contents loaded earlier:
- lookup results;
- where the auto-incrementing index lands across the red-to-green, green-to-blue and blue-to-red boundaries;
- that writes are dropped in colour 3 and while the arm bit is clear;
- the old value seen by a same-cycle read.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  parameter int COMP_W    = 8;                 // component width
  parameter int IN_W      = 16;                // width of colour value in a data write
  parameter int CFG_W     = 32;                // register word width
  parameter int NCH       = 3;                 // colour channels
  parameter int CH_W      = 2;                 // colour select field width
  parameter int ARM_BIT   = 30;                // table write arm bit in address word
  localparam int TBL_DEPTH = 2 ** COMP_W;
  localparam int IDX_W     = CH_W + COMP_W;
  localparam int LAST_IDX  = NCH * TBL_DEPTH - 1;

  typedef struct packed {
    logic [NCH-1:0]    wrSel;    // one-hot table select for this cycle's write
    logic [COMP_W-1:0] wrEntry;  // entry written
    logic [COMP_W-1:0] wrData;   // value written
  } tbl_wr_t;
endpackage

// File: rtl/gamma_ctrl.sv
module gamma_ctrl
  import gamma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [CFG_W-1:0] cfgWData,
  output tbl_wr_t          stb
);
  logic [IDX_W-1:0] wrIdx;
  logic             armed;
  logic             dataWr;

  assign dataWr = cfgWrEn && cfgSel && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrIdx <= '0;
      armed <= 1'b0;
    end else if (cfgWrEn && !cfgSel) begin
      wrIdx <= cfgWData[IDX_W-1:0];
      armed <= cfgWData[ARM_BIT];
    end else if (dataWr) begin
      if (wrIdx == IDX_W'(LAST_IDX)) wrIdx <= '0;
      else                          wrIdx <= wrIdx + 1'b1;
    end
  end

  always_comb begin
    stb         = '0;
    stb.wrEntry = wrIdx[COMP_W-1:0];
    stb.wrData  = cfgWData[IN_W-1 -: COMP_W];
    for (int c = 0; c < NCH; c++)
      stb.wrSel[c] = dataWr && (wrIdx[IDX_W-1 -: CH_W] == CH_W'(c));
  end
endmodule

// File: rtl/gamma_datapath.sv
module gamma_datapath
  import gamma_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  tbl_wr_t                    stb,
  input  logic                       pixValid,
  input  logic                       gammaEn,
  input  logic [NCH-1:0][COMP_W-1:0] pixIn,
  output logic                       outValid,
  output logic [NCH-1:0][COMP_W-1:0] outPix
);
  logic [NCH-1:0][COMP_W-1:0] pixQ;
  logic                       enQ;
  logic                       validQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validQ <= 1'b0;
      enQ    <= 1'b0;
      pixQ   <= '0;
    end else begin
      validQ <= pixValid;
      if (pixValid) begin
        enQ  <= gammaEn;
        pixQ <= pixIn;
      end
    end
  end

  assign outValid = validQ;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [COMP_W-1:0] tbl [TBL_DEPTH];
    logic [COMP_W-1:0] lookQ;

    always_ff @(posedge clk) begin
      if (stb.wrSel[c]) tbl[stb.wrEntry] <= stb.wrData;
      if (pixValid)     lookQ <= tbl[pixIn[c]];
    end

    assign outPix[c] = enQ ? lookQ : pixQ[c];
  end
endmodule

// File: rtl/gamma_lut_stage.sv
module gamma_lut_stage
  import gamma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [CFG_W-1:0] cfgWData,
  input  logic             gammaEn,
  input  logic             pixValid,
  input  logic [COMP_W-1:0] pixR,
  input  logic [COMP_W-1:0] pixG,
  input  logic [COMP_W-1:0] pixB,
  output logic             outValid,
  output logic [COMP_W-1:0] outR,
  output logic [COMP_W-1:0] outG,
  output logic [COMP_W-1:0] outB
);
  tbl_wr_t                    stb;
  logic [NCH-1:0][COMP_W-1:0] pixIn;
  logic [NCH-1:0][COMP_W-1:0] outPix;

  assign pixIn = {pixB, pixG, pixR};

  gamma_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWData(cfgWData), .stb(stb)
  );

  gamma_datapath i_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .pixValid(pixValid),
    .gammaEn(gammaEn), .pixIn(pixIn), .outValid(outValid), .outPix(outPix)
  );

  assign outR = outPix[0];
  assign outG = outPix[1];
  assign outB = outPix[2];
endmodule

// File: rtl/gamma_lut_checker.sv
module gamma_lut_checker
  import gamma_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfgWrEn,
  input logic              cfgSel,
  input logic              gammaEn,
  input logic              pixValid,
  input logic [COMP_W-1:0] pixR,
  input logic [COMP_W-1:0] pixG,
  input logic [COMP_W-1:0] pixB,
  input logic              outValid,
  input logic [COMP_W-1:0] outR,
  input logic [COMP_W-1:0] outG,
  input logic [COMP_W-1:0] outB,
  input tbl_wr_t           stb
);
  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pixValid |=> outValid);
  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pixValid |=> !outValid);
  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pixValid |=> ($stable(outR) && $stable(outG) && $stable(outB)));
  // R2
  bypass_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pixValid && !gammaEn) |=>
      (outR == $past(pixR) && outG == $past(pixG) && outB == $past(pixB)));
  // R4
  one_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb.wrSel));
  // R5, R6
  write_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb.wrSel) |-> (cfgWrEn && cfgSel));
endmodule

bind gamma_lut_stage gamma_lut_checker i_chk (
  .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
  .gammaEn(gammaEn), .pixValid(pixValid), .pixR(pixR), .pixG(pixG),
  .pixB(pixB), .outValid(outValid), .outR(outR), .outG(outG),
  .outB(outB), .stb(stb)
);

// File: tb/test_gamma_lut_stage.sv
`timescale 1ns/1ps
module test_gamma_lut_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgWData = '0;
  logic        gammaEn = 1'b0;
  logic        pixValid = 1'b0;
  logic [7:0]  pixR = '0, pixG = '0, pixB = '0;
  logic        outValid;
  logic [7:0]  outR, outG, outB;

  int checks = 0;
  int failures = 0;
  string scen = "reset";

  always #5 clk = ~clk;

  gamma_lut_stage i_gamma_lut_stage (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWData(cfgWData), .gammaEn(gammaEn), .pixValid(pixValid),
    .pixR(pixR), .pixG(pixG), .pixB(pixB), .outValid(outValid),
    .outR(outR), .outG(outG), .outB(outB)
  );

  // behavioural reference model
  int tblM [3][256];
  int idxM;
  bit armM;
  bit expValid;
  bit expLook;
  int expR, expG, expB;

  always @(posedge clk) begin
    if (!rst_n) begin
      idxM = 0; armM = 0; expValid = 0; expLook = 0;
      expR = 0; expG = 0; expB = 0;
    end else begin
      expValid = pixValid;
      if (pixValid) begin
        expLook = gammaEn;
        if (gammaEn) begin
          expR = tblM[0][pixR]; expG = tblM[1][pixG]; expB = tblM[2][pixB];
        end else begin
          expR = pixR; expG = pixG; expB = pixB;
        end
      end
      if (cfgWrEn) begin
        if (!cfgSel) begin
          idxM = cfgWData % 1024;
          armM = cfgWData[30];
        end else if (armM) begin
          if (idxM / 256 < 3) tblM[idxM / 256][idxM % 256] = (cfgWData >> 8) % 256;
          idxM = (idxM == 767) ? 0 : (idxM + 1) % 1024;
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s [%s] act=%0d exp=%0d", req, what, scen, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7", "outValid", outValid, expValid);
      chk(expLook ? "R1" : "R2", "outR", outR, expR);
      chk(expLook ? "R1" : "R2", "outG", outG, expG);
      chk(expLook ? "R1" : "R2", "outB", outB, expB);
    end
  end

  function automatic int fval(int c, int i);
    return (i * 7 + c * 61 + 3) % 256;
  endfunction

  // one cycle: drive inputs after a falling edge, return at the next one
  task automatic cyc(bit wr, bit sel, logic [31:0] d, bit v, int r, int g, int b, bit en);
    cfgWrEn = wr; cfgSel = sel; cfgWData = d;
    pixValid = v; pixR = 8'(r); pixG = 8'(g); pixB = 8'(b); gammaEn = en;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "outValid in reset", outValid, 0);
    chk("R9", "outR in reset", outR, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "outValid after reset", outValid, 0);
    chk("R9", "outB after reset", outB, 0);

    // R2, R7: bypass stream with gaps
    scen = "bypass";
    cyc(0, 0, 0, 1, 200, 13, 99, 0);
    chk("R2", "bypass outG", outG, 13);
    cyc(0, 0, 0, 0, 1, 2, 3, 0);
    chk("R7", "hold outR", outR, 200);
    chk("R7", "valid low", outValid, 0);

    // R5: writes before arming are dropped and do not move the index
    scen = "unarmed";
    for (int k = 0; k < 5; k++) cyc(1, 1, 32'h0000_FF00, 0, 0, 0, 0, 0);

    // R3, R4, R6: fill all three tables from index 0
    scen = "fill";
    cyc(1, 0, 32'h4000_0000, 0, 0, 0, 0, 0);
    for (int k = 0; k < 768; k++)
      cyc(1, 1, 32'h00A5_0000 | (fval(k / 256, k % 256) << 8) | (k % 256), 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 10, 20, 30, 1);
    chk("R3", "lookup R after fill", outR, fval(0, 10));
    chk("R5", "fill aligned G", outG, fval(1, 20));
    chk("R1", "lookup B after fill", outB, fval(2, 30));

    // R4: blue 255 wraps to red 0
    scen = "wrap";
    cyc(1, 0, 32'h4000_02FF, 0, 0, 0, 0, 0);
    cyc(1, 1, 32'h0000_C900, 0, 0, 0, 0, 0);
    cyc(1, 1, 32'h0000_EE00, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 255, 255, 1);
    chk("R4", "wrap to red 0", outR, 8'hEE);
    chk("R4", "blue 255", outB, 8'hC9);

    // R4, R6: green 255 then blue 0
    scen = "green-blue";
    cyc(1, 0, 32'h4000_01FF, 0, 0, 0, 0, 0);
    cyc(1, 1, 32'h0000_1100, 0, 0, 0, 0, 0);
    cyc(1, 1, 32'h0000_2200, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 255, 0, 1);
    chk("R4", "green 255", outG, 8'h11);
    chk("R4", "blue 0", outB, 8'h22);

    // R4: colour 3 drops writes and wraps to red 0
    scen = "colour3";
    cyc(1, 0, 32'h4000_03FE, 0, 0, 0, 0, 0);
    cyc(1, 1, 32'h0000_3300, 0, 0, 0, 0, 0);
    cyc(1, 1, 32'h0000_4400, 0, 0, 0, 0, 0);
    cyc(1, 1, 32'h0000_5500, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 1);
    chk("R4", "colour 3 wrap red 0", outR, 8'h55);
    chk("R4", "blue 0 untouched", outB, 8'h22);

    // R8: same-cycle write and read
    scen = "collide";
    cyc(1, 0, 32'h4000_0005, 0, 0, 0, 0, 0);
    cyc(1, 1, 32'h0000_6600, 1, 5, 5, 5, 1);
    chk("R8", "old value same cycle", outR, fval(0, 5));
    cyc(0, 0, 0, 1, 5, 5, 5, 1);
    chk("R8", "new value next cycle", outR, 8'h66);

    // R6, R5: clearing the arm bit blocks writes
    scen = "disarm";
    cyc(1, 0, 32'h0000_0005, 0, 0, 0, 0, 0);
    cyc(1, 1, 32'h0000_7700, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 5, 0, 0, 1);
    chk("R6", "disarmed entry kept", outR, 8'h66);

    // R1, R2, R7: mixed stream with toggling enable and gaps
    scen = "mixed";
    for (int k = 0; k < 300; k++)
      cyc(0, 0, 0, (k % 5) != 0, (k * 37) % 256, (k * 91 + 7) % 256, (k * 53 + 11) % 256, (k % 3) != 0);
    idle();
    idle();

    summary();
    $finish;
  end
endmodule